// File: doc/BRIEF.md
# Status Register with Dual Interrupt Masks

This block keeps the status word of a card-interface controller and turns it into two interrupt lines. The word is 22 bits wide. Its lower eleven bits latch one-cycle event pulses from the command and data units and hold them until the host clears them. Its upper eleven bits mirror the condition of the data FIFO and the command path, and hardware rewrites them whenever the FIFO engine signals an update.

The host reaches the block through a small register port. The port has a write strobe, a 2-bit word address, write data, and combinational read data. Four words are visible. Address 0 is the status word, which is read-only. Address 1 is the clear word: a write clears status bits, and a read returns zero. Addresses 2 and 3 hold interrupt masks 0 and 1. Each interrupt output is a registered OR of its own mask ANDed with the status word. The block does not generate the events and does not decode the wider address map.

Event bit meanings, by position: 0 command CRC error, 1 data CRC error, 2 command timeout, 3 data timeout, 4 transmit underrun, 5 receive overrun, 6 response received, 7 command sent without response, 8 data transfer end, 10 data block end. Bit 9 is reserved. Level bits 11..21 take `fifo_flags_i[0..10]`. In flag order these are: command in progress, transmit active, receive active, transmit half-empty, receive half-full, transmit full, receive full, transmit empty, receive empty, transmit data available, receive data available.

Top module: `stsirq_top`

## Requirements
- R1: After reset, the status word, both masks and both interrupt outputs are zero.
- R2: A high `evt_i[i]` at a clock edge sets status bit i after that edge, for i in 0..8 and 10. The bit then stays set until it is cleared. `evt_i[9]` is ignored, and status bit 9 always reads 0.
- R3: A write to address 1 clears, at that edge, each status bit i in 0..10 for which `reg_wdata_i[i]` is 1. All other status bits are unchanged.
- R4: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: When `fifo_upd_i` is high at an edge, status bits 21:11 are loaded from `fifo_flags_i` after that edge. Otherwise they hold their value. Clear writes never change them.
- R6: A write to address 2 or 3 stores `reg_wdata_i[21:0]` as mask 0 or mask 1. Reading that address returns the stored mask with bits 31:22 zero.
- R7: `irq_o[k]` equals the OR-reduction of (status AND mask k) as it stood one clock earlier.
- R8: A write to address 0 changes nothing. Reading address 1 returns zero. Reading address 0 returns the status word, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 11 | One-cycle event pulses, bit i sets status bit i |
| fifo_upd_i | input | 1 | Strobe to reload the level bits |
| fifo_flags_i | input | 11 | Current FIFO and command-path levels for status 21:11 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 2 | Registered interrupt lines, one per mask |

## Verification
The assertions check several rules on every cycle:
- stickiness of event bits when no clear write occurs;
- the effect of a clear write on the bits it names;
- set-over-clear priority;
- loading and holding of the level bits;
- the one-cycle relation between each interrupt and its masked status.

The read-back mapping cannot be shown by the assertions, and only the bench scenarios demonstrate it. These scenarios cover:
- that bit 9 stays low;
- that address 0 is read-only;
- the masked upper read bits;
- the exact cycle in which an interrupt rises after a mask write.

A behavioural reference model in the bench is compared against both outputs on every clock during a long randomized phase.

// File: rtl/stsirq_pkg.sv
package stsirq_pkg;
    localparam int STAT_W   = 22;
    localparam int EVT_W    = 11;
    localparam int LVL_W    = STAT_W - EVT_W;
    localparam int RSVD_BIT = 9;

    localparam logic [1:0] RA_STATUS = 2'd0;
    localparam logic [1:0] RA_CLEAR  = 2'd1;
    localparam logic [1:0] RA_MASK0  = 2'd2;

    // event bits that have a meaning (reserved position removed)
    function automatic logic [EVT_W-1:0] evt_keep();
        logic [EVT_W-1:0] m;
        m = '1;
        m[RSVD_BIT] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/stsirq_event_bank.sv
module stsirq_event_bank #(
    parameter int EVT_W = 11,
    parameter int RSVD  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] set_i,
    input  logic             clr_en_i,
    input  logic [EVT_W-1:0] clr_i,
    output logic [EVT_W-1:0] q_o
);
    logic unused_rsvd;
    assign unused_rsvd = set_i[RSVD] ^ clr_i[RSVD];

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        if (i == RSVD) begin : g_rsvd
            assign q_o[i] = 1'b0;
        end else begin : g_flop
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (set_i[i])
                    bit_q <= 1'b1;              // set wins over clear
                else if (clr_en_i && clr_i[i])
                    bit_q <= 1'b0;
            end
            assign q_o[i] = bit_q;
        end
    end
endmodule

// File: rtl/stsirq_level_bank.sv
module stsirq_level_bank #(
    parameter int LVL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [LVL_W-1:0] flags_i,
    output logic [LVL_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (upd_i)
            q_o <= flags_i;     // whole field dropped and reloaded
    end
endmodule

// File: rtl/stsirq_mask_unit.sv
module stsirq_mask_unit #(
    parameter int STAT_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (wr_i)
            mask_o <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |(stat_i & mask_o);
    end
endmodule

// File: rtl/stsirq_top.sv
module stsirq_top
    import stsirq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2,
    parameter int NUM_IRQ = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_W-1:0]   evt_i,
    input  logic               fifo_upd_i,
    input  logic [LVL_W-1:0]   fifo_flags_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [NUM_IRQ-1:0] irq_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(RA_STATUS);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(RA_CLEAR);
    localparam int                MBASE    = int'(RA_MASK0);

    logic [EVT_W-1:0]          evt_q;
    logic [LVL_W-1:0]          lvl_q;
    logic [STAT_W-1:0]         stat_q;
    logic [NUM_IRQ*STAT_W-1:0] mask_flat;
    logic                      clr_hit;
    logic                      unused_hi;

    assign unused_hi = ^reg_wdata_i[DATA_W-1:STAT_W];
    assign clr_hit   = reg_wr_i && (reg_addr_i == A_CLEAR);
    assign stat_q    = {lvl_q, evt_q};

    stsirq_event_bank #(.EVT_W(EVT_W), .RSVD(RSVD_BIT)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_i),
        .clr_en_i (clr_hit),
        .clr_i    (reg_wdata_i[EVT_W-1:0]),
        .q_o      (evt_q)
    );

    stsirq_level_bank #(.LVL_W(LVL_W)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (fifo_upd_i),
        .flags_i (fifo_flags_i),
        .q_o     (lvl_q)
    );

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
        logic wr_k;
        assign wr_k = reg_wr_i && (reg_addr_i == ADDR_W'(MBASE + k));
        stsirq_mask_unit #(.STAT_W(STAT_W)) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_k),
            .wdata_i (reg_wdata_i[STAT_W-1:0]),
            .stat_i  (stat_q),
            .mask_o  (mask_flat[k*STAT_W +: STAT_W]),
            .irq_o   (irq_o[k])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == A_STATUS)
            reg_rdata_o[STAT_W-1:0] = stat_q;
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (reg_addr_i == ADDR_W'(MBASE + k))
                reg_rdata_o[STAT_W-1:0] = mask_flat[k*STAT_W +: STAT_W];
        end
    end
endmodule

// File: rtl/stsirq_chk.sv
module stsirq_chk
    import stsirq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2,
    parameter int NUM_IRQ = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [EVT_W-1:0]          evt_i,
    input logic                      fifo_upd_i,
    input logic [LVL_W-1:0]          fifo_flags_i,
    input logic                      reg_wr_i,
    input logic [ADDR_W-1:0]         reg_addr_i,
    input logic [DATA_W-1:0]         reg_wdata_i,
    input logic [STAT_W-1:0]         stat_q,
    input logic [NUM_IRQ*STAT_W-1:0] mask_flat,
    input logic [NUM_IRQ-1:0]        irq_o
);
    localparam logic [EVT_W-1:0] KEEP = evt_keep();

    logic             clr_hit;
    logic [EVT_W-1:0] ev_m;
    logic [EVT_W-1:0] lo_q;
    logic [LVL_W-1:0] hi_q;

    assign clr_hit = reg_wr_i && (reg_addr_i == ADDR_W'(RA_CLEAR));
    assign ev_m    = evt_i & KEEP;
    assign lo_q    = stat_q[EVT_W-1:0];
    assign hi_q    = stat_q[STAT_W-1:EVT_W];

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_m != '0) |=> ((lo_q & $past(ev_m)) == $past(ev_m)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> (($past(lo_q) & ~lo_q) == '0));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((lo_q & $past(reg_wdata_i[EVT_W-1:0] & ~evt_i)) == '0));

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && ((ev_m & reg_wdata_i[EVT_W-1:0]) != '0))
        |=> ((lo_q & $past(ev_m & reg_wdata_i[EVT_W-1:0])) == $past(ev_m & reg_wdata_i[EVT_W-1:0])));

    assert_level_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_upd_i |=> (hi_q == $past(fifo_flags_i)));

    assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_upd_i |=> $stable(hi_q));

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq_chk
        assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o[k] == $past(|(stat_q & mask_flat[k*STAT_W +: STAT_W]))));
    end
endmodule

bind stsirq_top stsirq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .fifo_upd_i   (fifo_upd_i),
    .fifo_flags_i (fifo_flags_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .stat_q       (stat_q),
    .mask_flat    (mask_flat),
    .irq_o        (irq_o)
);

// File: tb/test_stsirq_top.sv
`timescale 1ns/1ps
module test_stsirq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt = '0;
    logic        upd = 1'b0;
    logic [10:0] flags = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    stsirq_top i_stsirq_top (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .fifo_upd_i(upd),
        .fifo_flags_i(flags), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #2 clk = ~clk;   // 250 MHz

    // behavioural reference model
    logic [21:0] m_stat;
    logic [21:0] m_mask [2];
    logic [1:0]  m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0; m_mask[0] = '0; m_mask[1] = '0; m_irq = '0;
        end else begin
            logic [21:0] nxt;
            m_irq[0] = |(m_stat & m_mask[0]);
            m_irq[1] = |(m_stat & m_mask[1]);
            nxt = m_stat;
            if (wr && addr == 2'd1) nxt[10:0] = nxt[10:0] & ~wdata[10:0];
            nxt[10:0] = nxt[10:0] | (evt & 11'h5FF);
            if (upd) nxt[21:11] = flags;
            if (wr && addr == 2'd2) m_mask[0] = wdata[21:0];
            if (wr && addr == 2'd3) m_mask[1] = wdata[21:0];
            m_stat = nxt;
        end
    end

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {10'd0, m_stat};
            2'd2:    return {10'd0, m_mask[0]};
            2'd3:    return {10'd0, m_mask[1]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 irq vs model", {30'd0, irq}, {30'd0, m_irq});
            chk("R2 readback vs model", rdata, m_read(addr));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        addr = 2'd0; #0; chk("R1 status after reset", rdata, 32'h0);
        chk("R1 irq after reset", {30'd0, irq}, 32'h0);
        addr = 2'd2; #1; chk("R1 mask0 after reset", rdata, 32'h0);
        addr = 2'd3; #1; chk("R1 mask1 after reset", rdata, 32'h0);
        tick(); addr = 2'd0;

        // R2 event set, reserved bit 9 ignored
        evt = 11'h201; tick(); evt = '0;
        @(negedge clk); chk("R2 bit0 set, bit9 ignored", rdata, 32'h001);
        repeat (3) tick();
        @(negedge clk); chk("R2 sticky", rdata, 32'h001);
        tick();
        evt = 11'h400; tick(); evt = '0;
        @(negedge clk); chk("R2 bit10 set", rdata, 32'h401);

        // R3 clear
        tick();
        reg_write(2'd1, 32'h001); addr = 2'd0;
        @(negedge clk); chk("R3 clear bit0", rdata, 32'h400);

        // R4 set beats clear
        tick();
        evt = 11'h400; reg_write(2'd1, 32'h400); evt = '0; addr = 2'd0;
        @(negedge clk); chk("R4 set wins", rdata, 32'h400);

        // R5 level bits
        tick();
        upd = 1'b1; flags = 11'h7FF; tick(); upd = 1'b0; flags = '0;
        @(negedge clk); chk("R5 level load", rdata, 32'h3FFC00);
        tick();
        reg_write(2'd1, 32'hFFFF_FFFF); addr = 2'd0;
        @(negedge clk); chk("R5 clear spares level bits", rdata, 32'h3FF800);
        tick();
        upd = 1'b1; flags = 11'h0A5; tick(); upd = 1'b0;
        @(negedge clk); chk("R5 level reload", rdata, 32'h052800);

        // R8 read-only status, clear reads zero
        tick();
        reg_write(2'd0, 32'hFFFF_FFFF); addr = 2'd0;
        @(negedge clk); chk("R8 status write ignored", rdata, 32'h052800);
        tick(); addr = 2'd1;
        @(negedge clk); chk("R8 clear reads zero", rdata, 32'h0);

        // R6 masks, R7 irq timing
        tick();
        reg_write(2'd2, 32'hFFFF_FFFF); addr = 2'd2;
        @(negedge clk); chk("R6 mask0 readback", rdata, 32'h3FFFFF);
        chk("R7 irq0 not yet", {31'd0, irq[0]}, 32'h0);
        tick();
        @(negedge clk); chk("R7 irq0 raised", {31'd0, irq[0]}, 32'h1);
        tick();
        reg_write(2'd3, 32'hF000_0001); addr = 2'd3;
        @(negedge clk); chk("R6 mask1 readback", rdata, 32'h000001);
        tick();
        evt = 11'h001; tick(); evt = '0;
        @(negedge clk); chk("R7 irq1 lags status", {31'd0, irq[1]}, 32'h0);
        tick();
        @(negedge clk); chk("R7 irq1 raised", {31'd0, irq[1]}, 32'h1);

        // randomized phase, model compared every clock
        for (int i = 0; i < 2000; i++) begin
            tick();
            evt   = ($urandom_range(0, 3) == 0) ? 11'($urandom) : '0;
            upd   = ($urandom_range(0, 4) == 0);
            flags = 11'($urandom);
            wr    = ($urandom_range(0, 2) == 0);
            addr  = 2'($urandom);
            wdata = $urandom;
        end
        tick();
        evt = '0; upd = 1'b0; wr = 1'b0;
        repeat (2) tick();
        @(negedge clk);
        finish_run();
    end
endmodule